// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer for 4 KB pages. It turns a virtual page number into a physical frame number. The low 12 bits of the address are the page offset and pass through unchanged. Each slot keeps a valid flag, a global flag, a 12-bit address-space identifier, a virtual page number and a frame number. A lookup presents a virtual address together with the identifier of the running context. It gets back, in the same cycle, a hit flag and the physical address.

A non-global translation belongs to the context that was current when it was written. It matches only for that context, so the same virtual page can be held several times under different identifiers. A global translation matches for every context. Three flush kinds remove translations: all of them, all non-global ones, or the non-global ones of a single identifier. A fill takes the lowest free slot. When no slot is free, a clock hand driven by per-slot reference bits picks the slot to overwrite.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, `lk_paddr` equals the stored frame number concatenated with `lk_vaddr[11:0]`, so the 12-bit page offset is never altered.
- R2: A non-global slot hits only when `lk_valid` is 1, its page number equals `lk_vaddr[31:12]`, and its stored identifier equals `lk_asid`. When there is no hit, `lk_hit` is 0 and `lk_paddr` is all zeros.
- R3: Slots with the same virtual page and different identifiers can be valid at the same time. Each one returns its own frame number to its own identifier.
- R4: A slot filled with `fl_global`=1 hits for any value of `lk_asid`.
- R5: `inv_op`=1 removes every slot, global ones included.
- R6: `inv_op`=2 removes every non-global slot and keeps every global slot.
- R7: `inv_op`=3 removes only the non-global slots whose identifier equals `inv_asid`. Global slots and slots of other identifiers stay. `inv_op`=0 means no invalidate.
- R8: After synchronous active-low reset, every slot is empty and no lookup hits.
- R9: A fill that finds an empty slot writes the lowest-numbered empty slot and evicts nothing.
- R10: With all slots full, a fill scans from the clock hand. It clears each set reference bit it passes, overwrites the first slot whose bit is already clear, and leaves the hand just past that slot. A slot's reference bit is set when the slot is filled and again on each hit. If every bit is set, the hand's own slot is overwritten after one full sweep.
- R11: A fill or an invalidate shows up in lookups from the next clock edge. When `fl_en` and a nonzero `inv_op` arrive in the same cycle, the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 12 | Identifier of the current context |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_paddr | output | 32 | Translated address, zero on a miss |
| fl_en | input | 1 | Write a new translation |
| fl_vpn | input | 20 | Virtual page number to store |
| fl_pfn | input | 20 | Frame number to store |
| fl_asid | input | 12 | Identifier recorded with the translation |
| fl_global | input | 1 | Translation matches every context |
| inv_op | input | 2 | 0 none, 1 all, 2 non-global, 3 one identifier |
| inv_asid | input | 12 | Identifier for flush kind 3 |

## Verification
The bench stores one page under two identifiers and checks that each returns its own frame. If the identifier were not part of the compare, one of the two would return the wrong frame. Global slots are checked through both kinds of partial flush; a design that flushed them would miss where a hit is expected. The replacement check fills every slot, touches one slot so its reference bit is set again, and then confirms which slot each later fill evicted. A hand that ignored reference bits, or did not move past its victim, would evict a different slot than expected. The last check sends an invalidate and a fill in the same cycle; a design that let the fill through would hit on the new page.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer.
// Assumes: the invalidate kinds are encoded in two bits.
package tlb_pkg;
    typedef enum logic [1:0] {
        INV_NONE      = 2'd0,
        INV_ALL       = 2'd1,
        INV_NONGLOBAL = 2'd2,
        INV_BY_ASID   = 2'd3
    } inv_kind_e;
endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare for all slots, plus a priority mux for the frame number.
// Assumes: the slot state is held elsewhere. If several slots match,
// the lowest-numbered one wins.
module tlb_match #(
    parameter int N      = 4,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 12
) (
    input  logic                        look,
    input  logic [VPN_W-1:0]            look_vpn,
    input  logic [ASID_W-1:0]           look_asid,
    input  logic [N-1:0]                slot_valid,
    input  logic [N-1:0]                slot_global,
    input  logic [N-1:0][ASID_W-1:0]    slot_asid,
    input  logic [N-1:0][VPN_W-1:0]     slot_vpn,
    input  logic [N-1:0][PFN_W-1:0]     slot_pfn,
    output logic [N-1:0]                hit_vec,
    output logic                        hit,
    output logic [PFN_W-1:0]            hit_pfn
);
    // One comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = look && slot_valid[g] && (slot_vpn[g] == look_vpn)
                            && (slot_global[g] || (slot_asid[g] == look_asid));
    end

    // Pick the frame number of the lowest-numbered matching slot.
    always_comb begin
        hit     = 1'b0;
        hit_pfn = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_pfn = slot_pfn[i];
            end
        end
    end
endmodule

// File: rtl/tlb_clock_repl.sv
// Chooses the slot for a fill: the lowest empty slot if there is one,
// otherwise the slot picked by the clock hand using reference bits.
// Assumes: fill_go already excludes fills that an invalidate overrides.
module tlb_clock_repl #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     slot_valid,
    input  logic [N-1:0]     hit_vec,
    input  logic             fill_go,
    output logic [IDX_W-1:0] victim
);
    logic [N-1:0]     ref_q;
    logic [IDX_W-1:0] hand_q;
    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] scan_idx;
    logic [N-1:0]     sweep;
    logic             found;

    // Find the lowest-numbered empty slot.
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!slot_valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    // Walk from the hand: passed set bits go into the sweep mask; stop at the first clear bit.
    always_comb begin
        found    = 1'b0;
        scan_idx = hand_q;
        sweep    = '0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = int'(hand_q) + k;
            if (pos >= N) pos = pos - N;
            if (!found) begin
                if (!ref_q[pos]) begin
                    found    = 1'b1;
                    scan_idx = IDX_W'(pos);
                end else begin
                    sweep[pos] = 1'b1;
                end
            end
        end
        if (!found) scan_idx = hand_q;
    end

    assign victim = have_free ? free_idx : scan_idx;

    // Update the reference bits and the hand on fills and hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            hand_q <= '0;
        end else begin
            logic [N-1:0] nref;
            nref = ref_q;
            if (fill_go) begin
                if (!have_free) begin
                    nref   = nref & ~sweep;
                    hand_q <= (int'(scan_idx) == N - 1) ? '0 : scan_idx + 1'b1;
                end
                nref[victim] = 1'b1;
            end
            ref_q <= nref | hit_vec;
        end
    end
endmodule

// File: rtl/tlb_slot_array.sv
// Storage for the translation slots: applies invalidates and writes fills.
// Assumes: an invalidate and a fill never both act in one cycle,
// because the caller gates the fill.
module tlb_slot_array
    import tlb_pkg::*;
#(
    parameter int N      = 4,
    parameter int IDX_W  = 2,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  inv_kind_e                inv_kind,
    input  logic [ASID_W-1:0]        inv_asid,
    input  logic                     fill_go,
    input  logic [IDX_W-1:0]         fill_idx,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PFN_W-1:0]         fill_pfn,
    input  logic [ASID_W-1:0]        fill_asid,
    input  logic                     fill_global,
    output logic [N-1:0]             slot_valid,
    output logic [N-1:0]             slot_global,
    output logic [N-1:0][ASID_W-1:0] slot_asid,
    output logic [N-1:0][VPN_W-1:0]  slot_vpn,
    output logic [N-1:0][PFN_W-1:0]  slot_pfn
);
    // Apply the flush kind or the fill to the slot state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid  <= '0;
            slot_global <= '0;
            slot_asid   <= '0;
            slot_vpn    <= '0;
            slot_pfn    <= '0;
        end else begin
            case (inv_kind)
                INV_ALL:       slot_valid <= '0;
                INV_NONGLOBAL: slot_valid <= slot_valid & slot_global;
                INV_BY_ASID: begin
                    for (int i = 0; i < N; i++) begin
                        if (!slot_global[i] && (slot_asid[i] == inv_asid))
                            slot_valid[i] <= 1'b0;
                    end
                end
                default: begin
                    if (fill_go) begin
                        slot_valid[fill_idx]  <= 1'b1;
                        slot_global[fill_idx] <= fill_global;
                        slot_asid[fill_idx]   <= fill_asid;
                        slot_vpn[fill_idx]    <= fill_vpn;
                        slot_pfn[fill_idx]    <= fill_pfn;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/asid_tlb.sv
// Top of the translation buffer. Lookups are combinational; fills and
// invalidates update state on the next clock edge.
// Assumes: pages are 2**OFF_W bytes, and an invalidate overrides a fill in the same cycle.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fl_en,
    input  logic [VA_W-OFF_W-1:0] fl_vpn,
    input  logic [PA_W-OFF_W-1:0] fl_pfn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_global,
    input  logic [1:0]        inv_op,
    input  logic [ASID_W-1:0] inv_asid
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    inv_kind_e                      inv_kind;
    logic                           fill_go;
    logic [IDX_W-1:0]               victim;
    logic [ENTRIES-1:0]             slot_valid;
    logic [ENTRIES-1:0]             slot_global;
    logic [ENTRIES-1:0][ASID_W-1:0] slot_asid;
    logic [ENTRIES-1:0][VPN_W-1:0]  slot_vpn;
    logic [ENTRIES-1:0][PFN_W-1:0]  slot_pfn;
    logic [ENTRIES-1:0]             hit_vec;
    logic                           hit;
    logic [PFN_W-1:0]               hit_pfn;

    assign inv_kind = inv_kind_e'(inv_op);
    assign fill_go  = fl_en && (inv_kind == INV_NONE);

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_match (
        .look       (lk_valid),
        .look_vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .look_asid  (lk_asid),
        .slot_valid (slot_valid),
        .slot_global(slot_global),
        .slot_asid  (slot_asid),
        .slot_vpn   (slot_vpn),
        .slot_pfn   (slot_pfn),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .hit_pfn    (hit_pfn)
    );

    tlb_clock_repl #(.N(ENTRIES), .IDX_W(IDX_W)) u_repl (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_valid(slot_valid),
        .hit_vec   (hit_vec),
        .fill_go   (fill_go),
        .victim    (victim)
    );

    tlb_slot_array #(.N(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PFN_W(PFN_W),
                     .ASID_W(ASID_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .inv_kind   (inv_kind),
        .inv_asid   (inv_asid),
        .fill_go    (fill_go),
        .fill_idx   (victim),
        .fill_vpn   (fl_vpn),
        .fill_pfn   (fl_pfn),
        .fill_asid  (fl_asid),
        .fill_global(fl_global),
        .slot_valid (slot_valid),
        .slot_global(slot_global),
        .slot_asid  (slot_asid),
        .slot_vpn   (slot_vpn),
        .slot_pfn   (slot_pfn)
    );

    // Form the physical address: frame number over the untouched offset, zero on a miss.
    assign lk_hit   = hit;
    assign lk_paddr = hit ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
endmodule

// File: rtl/tlb_checker.sv
// Temporal checks on the translation buffer ports, attached by bind.
// Assumes: same parameters as the top module.
module tlb_checker #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int ASID_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic [PA_W-1:0]   lk_paddr,
    input logic              fl_en,
    input logic [VA_W-OFF_W-1:0] fl_vpn,
    input logic [PA_W-OFF_W-1:0] fl_pfn,
    input logic [ASID_W-1:0] fl_asid,
    input logic              fl_global,
    input logic [1:0]        inv_op,
    input logic [ASID_W-1:0] inv_asid
);
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0])); // R1
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0)); // R2
    AST_NO_LOOK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit); // R2
    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inv_op == 2'd1) |-> !lk_hit); // R5
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit); // R8
    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fl_en && (inv_op == 2'd0)) && lk_valid
         && (lk_vaddr[VA_W-1:OFF_W] == $past(fl_vpn))
         && ($past(fl_global) || (lk_asid == $past(fl_asid)))) |-> lk_hit); // R11
endmodule

bind asid_tlb tlb_checker #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ASID_W(ASID_W)) u_chk (.*);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [11:0] lk_asid = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        fl_en = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [19:0] fl_pfn = '0;
    logic [11:0] fl_asid = '0;
    logic        fl_global = 1'b0;
    logic [1:0]  inv_op = '0;
    logic [11:0] inv_asid = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    asid_tlb dut (.*);

    // kind: 0 lookup, 1 fill, 2 invalidate
    typedef struct packed {
        logic [1:0]  kind;
        logic [19:0] vpn;
        logic [19:0] pfn;
        logic [11:0] asid;
        logic        glb;
        logic [1:0]  inv;
        logic        exp_hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 20'h00010, 20'h00A00, 12'd5, 1'b0, 2'd0, 1'b0, 4'd0},
        '{2'd0, 20'h00010, 20'h00A00, 12'd5, 1'b0, 2'd0, 1'b1, 4'd11}, // R11 R1
        '{2'd0, 20'h00010, 20'h00000, 12'd6, 1'b0, 2'd0, 1'b0, 4'd2},  // R2
        '{2'd1, 20'h00010, 20'h00B00, 12'd6, 1'b0, 2'd0, 1'b0, 4'd0},
        '{2'd0, 20'h00010, 20'h00A00, 12'd5, 1'b0, 2'd0, 1'b1, 4'd3},  // R3
        '{2'd0, 20'h00010, 20'h00B00, 12'd6, 1'b0, 2'd0, 1'b1, 4'd3},  // R3
        '{2'd1, 20'h00020, 20'h00C00, 12'd5, 1'b1, 2'd0, 1'b0, 4'd0},
        '{2'd0, 20'h00020, 20'h00C00, 12'd9, 1'b0, 2'd0, 1'b1, 4'd4},  // R4
        '{2'd2, 20'h00000, 20'h00000, 12'd5, 1'b0, 2'd3, 1'b0, 4'd0},
        '{2'd0, 20'h00010, 20'h00000, 12'd5, 1'b0, 2'd0, 1'b0, 4'd7},  // R7
        '{2'd0, 20'h00010, 20'h00B00, 12'd6, 1'b0, 2'd0, 1'b1, 4'd7},  // R7
        '{2'd0, 20'h00020, 20'h00C00, 12'd5, 1'b0, 2'd0, 1'b1, 4'd7},  // R7
        '{2'd2, 20'h00000, 20'h00000, 12'd0, 1'b0, 2'd2, 1'b0, 4'd0},
        '{2'd0, 20'h00010, 20'h00000, 12'd6, 1'b0, 2'd0, 1'b0, 4'd6},  // R6
        '{2'd0, 20'h00020, 20'h00C00, 12'd1, 1'b0, 2'd0, 1'b1, 4'd6},  // R6
        '{2'd2, 20'h00000, 20'h00000, 12'd0, 1'b0, 2'd1, 1'b0, 4'd0},
        '{2'd0, 20'h00020, 20'h00000, 12'd1, 1'b0, 2'd0, 1'b0, 4'd5}   // R5
    };

    // Drive a lookup before the edge, check the combinational result, and keep it across the edge.
    task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic [11:0] asid,
                        input logic eh, input logic [19:0] epfn, input string tag);
        logic [31:0] ep;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        lk_asid  = asid;
        #1;
        ep = eh ? {epfn, off} : 32'h0;
        n_checks++;
        if (lk_hit !== eh || lk_paddr !== ep) begin
            n_fail++;
            $display("FAIL %s vpn=%h asid=%0d: hit=%b paddr=%h expected hit=%b paddr=%h",
                     tag, vpn, asid, lk_hit, lk_paddr, eh, ep);
        end
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [11:0] asid, input logic g);
        @(negedge clk);
        fl_en = 1'b1; fl_vpn = vpn; fl_pfn = pfn; fl_asid = asid; fl_global = g;
        @(posedge clk);
        #1 fl_en = 1'b0;
    endtask

    task automatic inval(input logic [1:0] op, input logic [11:0] asid);
        @(negedge clk);
        inv_op = op; inv_asid = asid;
        @(posedge clk);
        #1 inv_op = 2'd0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8: empty after reset
        look(20'h00000, 12'h000, 12'd0, 1'b0, 20'h0, "R8");
        look(20'h00010, 12'h123, 12'd5, 1'b0, 20'h0, "R8");

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].kind)
                2'd1: fill(VEC[i].vpn, VEC[i].pfn, VEC[i].asid, VEC[i].glb);
                2'd2: inval(VEC[i].inv, VEC[i].asid);
                default: look(VEC[i].vpn, 12'h5A3, VEC[i].asid, VEC[i].exp_hit, VEC[i].pfn,
                              $sformatf("R%0d", VEC[i].req));
            endcase
        end

        // R1: offset at the top of its range
        fill(20'hFFFFF, 20'h12345, 12'd7, 1'b0);
        look(20'hFFFFF, 12'hFFF, 12'd7, 1'b1, 20'h12345, "R1");
        inval(2'd1, 12'd0);

        // R9: four fills go into four empty slots, none is lost
        for (int k = 0; k < 4; k++) fill(20'h00100 + 20'(k), 20'h00E00 + 20'(k), 12'd1, 1'b0);
        for (int k = 0; k < 4; k++) look(20'h00100 + 20'(k), 12'h040, 12'd1, 1'b1,
                                         20'h00E00 + 20'(k), "R9");

        // R10: all bits set -> sweep, evict slot 0, hand moves to 1
        fill(20'h00104, 20'h00E04, 12'd1, 1'b0);
        look(20'h00100, 12'h040, 12'd1, 1'b0, 20'h0, "R10");
        // R10: slot 1 bit already cleared -> evicted, hand to 2
        fill(20'h00105, 20'h00E05, 12'd1, 1'b0);
        look(20'h00101, 12'h040, 12'd1, 1'b0, 20'h0, "R10");
        // R10: a hit sets slot 2 again, so the hand skips it and evicts slot 3
        look(20'h00102, 12'h040, 12'd1, 1'b1, 20'h00E02, "R10");
        fill(20'h00106, 20'h00E06, 12'd1, 1'b0);
        look(20'h00103, 12'h040, 12'd1, 1'b0, 20'h0, "R10");
        look(20'h00102, 12'h040, 12'd1, 1'b1, 20'h00E02, "R10");
        look(20'h00104, 12'h040, 12'd1, 1'b1, 20'h00E04, "R10");
        look(20'h00105, 12'h040, 12'd1, 1'b1, 20'h00E05, "R10");
        look(20'h00106, 12'h040, 12'd1, 1'b1, 20'h00E06, "R10");

        // R11: invalidate and fill in the same cycle -> fill dropped
        @(negedge clk);
        inv_op = 2'd1;
        fl_en = 1'b1; fl_vpn = 20'h00300; fl_pfn = 20'h00F00; fl_asid = 12'd2; fl_global = 1'b1;
        @(posedge clk);
        #1 inv_op = 2'd0; fl_en = 1'b0;
        look(20'h00300, 12'h000, 12'd2, 1'b0, 20'h0, "R11");
        look(20'h00104, 12'h040, 12'd1, 1'b0, 20'h0, "R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule